// File: doc/BRIEF.md
# Flagged-Bit Soft-Information Adjuster

This block sits in the turbo loop of a run-length-constrained storage read channel, between a soft-output equalizer and an LDPC decoder. For each bit position of a codeword it receives two signed fixed-point extrinsic LLRs: one produced by the equalizer and one produced by the decoder. It also receives a flag saying that detection logic upstream judged the bit to have been deliberately flipped at write time, and a second flag that asks for one-sided treatment. It returns the a priori LLR for the decoder, derived from the equalizer's extrinsic value, and the a priori LLR for the equalizer, derived from the decoder's extrinsic value.

Unflagged bits pass straight through. Flagged bits are handled by one of four policies: plain sign reversal, erasure, sign reversal with the magnitude replaced by the codeword's mean extrinsic magnitude, or sign reversal with the magnitude clipped at that mean. Each output direction uses the mean of its own source. A codeword is therefore stored while the two means build up, and it is read back once the means are known. The block has two banks, so one codeword can load while the previous one is emitted. The block assumes that the codeword length is at least 2.

Top module: `flip_llr_adjuster`

## Requirements
- R1: A bit whose flag is 0 is output unchanged in every mode. The decoder-bound output equals the equalizer extrinsic input, and the equalizer-bound output equals the decoder extrinsic input. The one-sided flag has no effect on such a bit.
- R2: In mode 0 (invert), both outputs of a flagged bit are the arithmetic negation of their sources. Negation saturates, so the most negative code gives the most positive code.
- R3: In mode 1 (erase), both outputs of a flagged, two-sided bit are zero.
- R4: In mode 2 (average), a flagged output has the opposite sign of its source, with a source of 0 treated as positive. Its magnitude is that direction's mean: floor(sum of |source| over the N positions of the codeword / N), where |most negative code| counts as 2^(W-1). A positive result saturates at 2^(W-1)-1.
- R5: In mode 3 (clip), a flagged output has the opposite sign of its source. Its magnitude is min(|source|, mean of that direction), with the mean defined as in R4 and the same saturation applied.
- R6: For a flagged bit whose one-sided flag is 1, the equalizer-bound output equals the decoder extrinsic input unchanged. The decoder-bound output follows the mode as in R2 to R5.
- R7: Samples are accepted on clock edges where in_valid is 1, and gaps are allowed. If the N-th sample of a codeword is accepted at edge E, position p of that codeword appears with out_valid=1 at edge E+2+p. out_last is 1 only for position N-1, and out_valid is 0 on every other edge.
- R8: The mode is sampled only together with the N-th sample of a codeword, and it applies to that whole codeword. The mode present on earlier samples has no effect.
- R9: A new codeword may be loaded while the previous one is being emitted, with no idle cycles. Each codeword uses its own means and its own mode.
- R10: While rst is 1, and after it is released, out_valid, out_last and both outputs are 0 until the first codeword is emitted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Input sample present this cycle |
| in_ley | input | W | Equalizer extrinsic LLR, two's complement |
| in_lev | input | W | Decoder extrinsic LLR, two's complement |
| in_flag | input | 1 | Bit detected as deliberately flipped |
| in_asym | input | 1 | One-sided treatment for a flagged bit |
| in_mode | input | 2 | Adjustment policy: 0 invert, 1 erase, 2 average, 3 clip |
| out_valid | output | 1 | Adjusted pair present this cycle |
| out_lav | output | W | A priori LLR towards the decoder |
| out_lay | output | W | A priori LLR towards the equalizer |
| out_last | output | 1 | Final position of the codeword |

## Verification
The hardest situation to reach is a codeword that completes on the very edge where the previous codeword's last word is read. At that point the banks, the per-bank means and the per-bank modes all hand over at once. The stimulus reaches it by streaming several codewords with no idle cycle between them and switching the mode each time. A second hard case is a mean equal to 2^(W-1) in average mode, where the positive result must saturate. A codeword made entirely of the most negative code produces it. Randomized mode values on the non-final samples show that only the final sample's mode is used.

// File: rtl/fla_pkg.sv
package fla_pkg;
  typedef enum logic [1:0] {
    ADJ_INVERT  = 2'd0,
    ADJ_ERASE   = 2'd1,
    ADJ_AVERAGE = 2'd2,
    ADJ_CLIP    = 2'd3
  } adj_mode_e;
endpackage

// File: rtl/fla_mean.sv
// Accumulates |llr| over one codeword and keeps one mean per bank.
module fla_mean #(
  parameter int N = 16,
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         smp_en,
  input  logic         smp_last,
  input  logic         smp_bank,
  input  logic [W-1:0] smp_llr,
  input  logic         sel_bank,
  output logic [W-1:0] mean_out
);
  localparam int AW = W + $clog2(N + 1);
  localparam logic [W-1:0] HALF = {1'b1, {(W-1){1'b0}}};

  logic [W-1:0]  mag;
  logic [AW-1:0] acc_q;
  logic [AW-1:0] acc_sum;
  logic [W-1:0]  mean_q [2];

  always_comb begin
    mag     = smp_llr[W-1] ? (~smp_llr + 1'b1) : smp_llr;
    acc_sum = acc_q + AW'(mag);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      acc_q     <= '0;
      mean_q[0] <= '0;
      mean_q[1] <= '0;
    end else if (smp_en) begin
      if (smp_last) begin
        acc_q            <= '0;
        mean_q[smp_bank] <= W'(acc_sum / AW'(N));
      end else begin
        acc_q <= acc_sum;
      end
    end
  end

  assign mean_out = mean_q[sel_bank];

  // R4: a mean of magnitudes never exceeds the largest magnitude
  a_r4_mean_in_range: assert property (@(posedge clk) disable iff (rst)
    (mean_q[0] <= HALF) && (mean_q[1] <= HALF));
endmodule

// File: rtl/fla_store.sv
// Simple dual-port codeword store with registered read (block RAM style).
module fla_store #(
  parameter int DEPTH = 32,
  parameter int DW    = 18
) (
  input  logic                     clk,
  input  logic                     wr_en,
  input  logic [$clog2(DEPTH)-1:0] wr_addr,
  input  logic [DW-1:0]            wr_data,
  input  logic                     rd_en,
  input  logic [$clog2(DEPTH)-1:0] rd_addr,
  output logic [DW-1:0]            rd_data
);
  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (wr_en) mem[wr_addr] <= wr_data;
    if (rd_en) rd_data <= mem[rd_addr];
  end
endmodule

// File: rtl/fla_shape.sv
// Per-direction adjustment of one LLR according to the selected policy.
module fla_shape #(
  parameter int W = 8
) (
  input  logic               [W-1:0] llr,
  input  logic                       flagged,
  input  logic                       hold,
  input  fla_pkg::adj_mode_e         mode,
  input  logic               [W-1:0] gamma,
  output logic               [W-1:0] adj_out
);
  import fla_pkg::*;
  localparam logic [W-1:0] POS_MAX = {1'b0, {(W-1){1'b1}}};

  logic [W-1:0] mag;
  logic [W-1:0] sel;

  always_comb begin
    mag = llr[W-1] ? (~llr + 1'b1) : llr;
    case (mode)
      ADJ_AVERAGE: sel = gamma;
      ADJ_CLIP:    sel = (mag > gamma) ? gamma : mag;
      default:     sel = mag;
    endcase
    if (!flagged || hold) begin
      adj_out = llr;
    end else if (mode == ADJ_ERASE) begin
      adj_out = '0;
    end else if (!llr[W-1]) begin
      adj_out = ~sel + 1'b1;
    end else begin
      adj_out = (sel > POS_MAX) ? POS_MAX : sel;
    end
  end
endmodule

// File: rtl/flip_llr_adjuster.sv
module flip_llr_adjuster #(
  parameter int N = 16,
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         in_valid,
  input  logic [W-1:0] in_ley,
  input  logic [W-1:0] in_lev,
  input  logic         in_flag,
  input  logic         in_asym,
  input  logic [1:0]   in_mode,
  output logic         out_valid,
  output logic [W-1:0] out_lav,
  output logic [W-1:0] out_lay,
  output logic         out_last
);
  import fla_pkg::*;

  localparam int IW    = $clog2(N);
  localparam int DEPTH = 2 * (1 << IW);
  localparam int AWD   = IW + 1;
  localparam int DW    = 2 * W + 2;
  localparam logic [IW-1:0] LAST_IDX = IW'(N - 1);
  localparam logic [W-1:0]  NEG_MIN  = {1'b1, {(W-1){1'b0}}};

  // write side
  logic [IW-1:0] wr_idx;
  logic          wr_bank;
  logic          wr_last;
  adj_mode_e     mode_q [2];

  // read side
  logic          rd_run;
  logic [IW-1:0] rd_idx;
  logic          rd_bank;
  logic          rd_vld;
  logic          rd_bank_q;
  logic          rd_last;
  logic [DW-1:0] rd_data;
  logic          rd_flag;
  logic          rd_asym;
  logic [W-1:0]  rd_ley;
  logic [W-1:0]  rd_lev;
  adj_mode_e     rd_mode;

  logic [W-1:0] src_llr [2];
  logic [W-1:0] gam     [2];
  logic [W-1:0] rd_src  [2];
  logic         rd_hold [2];
  logic [W-1:0] adj     [2];

  assign wr_last = (wr_idx == LAST_IDX);

  always_ff @(posedge clk) begin
    if (rst) begin
      wr_idx    <= '0;
      wr_bank   <= 1'b0;
      mode_q[0] <= ADJ_INVERT;
      mode_q[1] <= ADJ_INVERT;
      rd_run    <= 1'b0;
      rd_idx    <= '0;
      rd_bank   <= 1'b0;
    end else begin
      if (rd_run) begin
        rd_idx <= rd_idx + 1'b1;
        if (rd_idx == LAST_IDX) rd_run <= 1'b0;
      end
      if (in_valid) begin
        if (wr_last) begin
          wr_idx          <= '0;
          wr_bank         <= ~wr_bank;
          mode_q[wr_bank] <= adj_mode_e'(in_mode);
          rd_run          <= 1'b1;
          rd_idx          <= '0;
          rd_bank         <= wr_bank;
        end else begin
          wr_idx <= wr_idx + 1'b1;
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_vld    <= 1'b0;
      rd_bank_q <= 1'b0;
      rd_last   <= 1'b0;
    end else begin
      rd_vld    <= rd_run;
      rd_bank_q <= rd_bank;
      rd_last   <= rd_run && (rd_idx == LAST_IDX);
    end
  end

  fla_store #(.DEPTH(DEPTH), .DW(DW)) u_store (
    .clk     (clk),
    .wr_en   (in_valid),
    .wr_addr ({wr_bank, wr_idx}),
    .wr_data ({in_flag, in_asym, in_ley, in_lev}),
    .rd_en   (rd_run),
    .rd_addr ({rd_bank, rd_idx}),
    .rd_data (rd_data)
  );

  assign rd_flag = rd_data[DW-1];
  assign rd_asym = rd_data[DW-2];
  assign rd_ley  = rd_data[2*W-1:W];
  assign rd_lev  = rd_data[W-1:0];
  assign rd_mode = mode_q[rd_bank_q];

  // direction 0: equalizer extrinsic -> decoder; direction 1: decoder extrinsic -> equalizer
  assign src_llr[0] = in_ley;
  assign src_llr[1] = in_lev;
  assign rd_src[0]  = rd_ley;
  assign rd_src[1]  = rd_lev;
  assign rd_hold[0] = 1'b0;
  assign rd_hold[1] = rd_asym;

  for (genvar d = 0; d < 2; d++) begin : g_dir
    fla_mean #(.N(N), .W(W)) u_mean (
      .clk      (clk),
      .rst      (rst),
      .smp_en   (in_valid),
      .smp_last (wr_last),
      .smp_bank (wr_bank),
      .smp_llr  (src_llr[d]),
      .sel_bank (rd_bank_q),
      .mean_out (gam[d])
    );
    fla_shape #(.W(W)) u_shape (
      .llr     (rd_src[d]),
      .flagged (rd_flag),
      .hold    (rd_hold[d]),
      .mode    (rd_mode),
      .gamma   (gam[d]),
      .adj_out (adj[d])
    );
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      out_last  <= 1'b0;
      out_lav   <= '0;
      out_lay   <= '0;
    end else begin
      out_valid <= rd_vld;
      out_last  <= rd_last;
      out_lav   <= rd_vld ? adj[0] : '0;
      out_lay   <= rd_vld ? adj[1] : '0;
    end
  end

  function automatic logic [W-1:0] mag_of(input logic [W-1:0] x);
    return x[W-1] ? (~x + 1'b1) : x;
  endfunction

  a_r1_pass_through: assert property (@(posedge clk) disable iff (rst)
    rd_vld && !rd_flag |=> (out_lav == $past(rd_ley)) && (out_lay == $past(rd_lev)));

  a_r2_invert: assert property (@(posedge clk) disable iff (rst)
    rd_vld && rd_flag && (rd_mode == ADJ_INVERT) && (rd_ley != NEG_MIN)
    |=> out_lav == (~$past(rd_ley) + 1'b1));

  a_r3_erase: assert property (@(posedge clk) disable iff (rst)
    rd_vld && rd_flag && !rd_asym && (rd_mode == ADJ_ERASE)
    |=> (out_lav == '0) && (out_lay == '0));

  a_r5_clip_bound: assert property (@(posedge clk) disable iff (rst)
    rd_vld && rd_flag && (rd_mode == ADJ_CLIP) |=> mag_of(out_lav) <= $past(gam[0]));

  a_r6_one_sided: assert property (@(posedge clk) disable iff (rst)
    rd_vld && rd_flag && rd_asym |=> out_lay == $past(rd_lev));

  a_r7_last_in_frame: assert property (@(posedge clk) disable iff (rst)
    out_last |-> out_valid);

  a_r9_no_overrun: assert property (@(posedge clk) disable iff (rst)
    in_valid && wr_last && rd_run |-> rd_idx == LAST_IDX);
endmodule

// File: tb/flip_llr_adjuster_bench.sv
module flip_llr_adjuster_bench;
  localparam int N = 6;
  localparam int W = 8;
  localparam int PMAX = (1 << (W - 1)) - 1;
  localparam int NMIN = -(1 << (W - 1));

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #5 clk = ~clk;

  logic         in_valid = 1'b0;
  logic [W-1:0] in_ley = '0;
  logic [W-1:0] in_lev = '0;
  logic         in_flag = 1'b0;
  logic         in_asym = 1'b0;
  logic [1:0]   in_mode = 2'd0;
  logic         out_valid;
  logic [W-1:0] out_lav;
  logic [W-1:0] out_lay;
  logic         out_last;

  flip_llr_adjuster #(.N(N), .W(W)) u_flip_llr_adjuster (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_ley(in_ley), .in_lev(in_lev),
    .in_flag(in_flag), .in_asym(in_asym), .in_mode(in_mode),
    .out_valid(out_valid), .out_lav(out_lav), .out_lay(out_lay), .out_last(out_last)
  );

  typedef struct {
    int    cyc;
    int    lav;
    int    lay;
    bit    last;
    string tag;
  } exp_t;

  exp_t  eq[$];
  int    fy[$];
  int    fv[$];
  bit    ff[$];
  bit    fa[$];
  int    cyc = 0;
  int    n_chk = 0;
  int    n_fail = 0;
  string ftag = "";

  always @(posedge clk) cyc <= cyc + 1;

  always @(posedge clk) begin
    if (cyc > 20000) begin
      n_fail = n_fail + 1;
      n_chk  = n_chk + 1;
      $display("FAIL R7 watchdog: actual cycle %0d expected below 20000", cyc);
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  function automatic int absv(int x);
    return (x < 0) ? -x : x;
  endfunction

  // behavioural reference for one direction
  function automatic int adj(int x, bit f, bit hold, int md, int g);
    int m;
    int r;
    if (!f || hold) return x;
    case (md)
      0: r = -x;
      1: r = 0;
      2: r = (x >= 0) ? -g : g;
      default: begin
        m = absv(x);
        if (m > g) m = g;
        r = (x >= 0) ? -m : m;
      end
    endcase
    if (r > PMAX) r = PMAX;
    return r;
  endfunction

  // codeword complete at edge le: schedule its outputs (R7, R8: mode of last sample)
  task automatic build_frame(int le, int md);
    int sy = 0;
    int sv = 0;
    int gy;
    int gv;
    exp_t e;
    string mt [4] = '{"R2", "R3", "R4", "R5"};
    for (int i = 0; i < N; i++) begin
      sy += absv(fy[i]);
      sv += absv(fv[i]);
    end
    gy = sy / N;
    gv = sv / N;
    for (int p = 0; p < N; p++) begin
      e.cyc  = le + 2 + p;
      e.lav  = adj(fy[p], ff[p], 1'b0, md, gy);
      e.lay  = adj(fv[p], ff[p], fa[p], md, gv);
      e.last = (p == N - 1);
      e.tag  = !ff[p] ? "R1" : (fa[p] ? "R6" : mt[md]);
      e.tag  = {e.tag, " ", ftag};
      eq.push_back(e);
    end
    fy.delete(); fv.delete(); ff.delete(); fa.delete();
  endtask

  task automatic check_cycle();
    exp_t e;
    n_chk++;
    if (eq.size() > 0 && eq[0].cyc == cyc) begin
      e = eq.pop_front();
      if (out_valid !== 1'b1 || int'($signed(out_lav)) != e.lav ||
          int'($signed(out_lay)) != e.lay || out_last !== e.last) begin
        n_fail++;
        $display("FAIL %s cyc %0d: valid/lav/lay/last actual %0b/%0d/%0d/%0b expected 1/%0d/%0d/%0b",
                 e.tag, cyc, out_valid, $signed(out_lav), $signed(out_lay), out_last,
                 e.lav, e.lay, e.last);
      end
    end else if (out_valid !== 1'b0 || out_last !== 1'b0) begin
      n_fail++;
      $display("FAIL R7 cyc %0d: valid/last actual %0b/%0b expected 0/0", cyc, out_valid, out_last);
    end
  endtask

  task automatic step(bit v, int y, int vv, bit f, bit a, logic [1:0] md);
    @(negedge clk);
    check_cycle();
    in_valid = v;
    in_ley   = y[W-1:0];
    in_lev   = vv[W-1:0];
    in_flag  = f;
    in_asym  = a;
    in_mode  = md;
    if (v) begin
      fy.push_back(y); fv.push_back(vv); ff.push_back(f); fa.push_back(a);
      if (fy.size() == N) build_frame(cyc + 1, int'(md));
    end
  endtask

  // kind 0: random with extremes, 1: all most-negative, 2: small values
  task automatic send_frame(logic [1:0] md, int kind, bit gaps, string tag);
    int y;
    int v;
    bit f;
    bit a;
    ftag = tag;
    for (int i = 0; i < N; i++) begin
      if (gaps) repeat ($urandom_range(0, 2)) step(1'b0, 0, 0, 1'b0, 1'b0, 2'($urandom));
      case (kind)
        1: begin y = NMIN; v = NMIN; end
        2: begin y = int'($urandom_range(0, 6)) - 3; v = int'($urandom_range(0, 6)) - 3; end
        default: begin
          y = int'($urandom_range(0, 255)) - 128;
          v = int'($urandom_range(0, 255)) - 128;
          if (i == 0) y = NMIN;
          if (i == 1) v = PMAX;
          if (i == 2) begin y = 0; v = 0; end
        end
      endcase
      f = (i < 3) ? 1'b1 : ($urandom_range(0, 3) != 0);
      a = (i == 1) ? 1'b1 : ($urandom_range(0, 2) == 0);
      // R8: mode on non-final samples is noise
      step(1'b1, y, v, f, a, (i == N - 1) ? md : 2'($urandom));
    end
  endtask

  initial begin
    rst = 1'b1;
    repeat (3) @(negedge clk);
    n_chk++;
    if (out_valid !== 1'b0 || out_last !== 1'b0 || out_lav !== '0 || out_lay !== '0) begin
      n_fail++;
      $display("FAIL R10 reset: valid/last/lav/lay actual %0b/%0b/%0d/%0d expected 0/0/0/0",
               out_valid, out_last, out_lav, out_lay);
    end
    rst = 1'b0;
    step(1'b0, 0, 0, 1'b0, 1'b0, 2'd0);
    step(1'b0, 0, 0, 1'b0, 1'b0, 2'd0);
    send_frame(2'd0, 0, 1'b0, "R8");
    send_frame(2'd1, 0, 1'b1, "R8");
    send_frame(2'd2, 0, 1'b0, "R9");
    send_frame(2'd3, 0, 1'b0, "R9");
    send_frame(2'd2, 1, 1'b0, "R4 sat");
    send_frame(2'd0, 1, 1'b0, "R2 sat");
    send_frame(2'd3, 2, 1'b1, "");
    send_frame(2'd2, 2, 1'b0, "R9");
    send_frame(2'd3, 1, 1'b1, "");
    for (int k = 0; k < 12; k++) send_frame(2'(k), (k % 5 == 4) ? 2 : 0, (k % 3 == 0), "R9");
    repeat (N + 6) step(1'b0, 0, 0, 1'b0, 1'b0, 2'd0);
    n_chk++;
    if (eq.size() != 0) begin
      n_fail++;
      $display("FAIL R7 pending outputs: actual %0d expected 0", eq.size());
    end
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule